// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management master for Ethernet PHYs. Software controls it through one 32-bit command and status word. Writing the word with the busy bit set starts one management frame on the MDC clock and the MDIO data line. The frame can use the clause 22 format or the clause 45 format. Clause 45 accesses take two frames: software first sends an address frame, then waits for busy to clear, then sends the read or write frame.

For a read, the master releases the MDIO line during the turnaround and data bits. It samples the PHY's reply on each rising MDC edge. It places the 16 sampled bits in the low half of the word at the same moment that busy clears. The receive buffer is cleared every time a frame is launched. As a result, a read from a PHY that is absent returns the pull-up value and never the result of an earlier frame. MDC comes from the system clock through a parameterised divider, and its default rate is 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: Command word fields are: busy in bit 31, ready in bit 30, register or device address in bits 29:25, PHY address in bits 24:20, opcode in bits 19:18, start code in bits 17:16 and data in bits 15:0. Reading the word returns the stored fields, and bit 30 reads as the inverse of busy. A write made while idle with bit 31 clear stores the fields and starts no frame.
- R2: A write made while idle with bit 31 set reads back busy from the next cycle. Busy clears exactly 64 MDC periods after the launch, that is, 128 times HALF system clocks.
- R3: Each frame carries, in order: 32 ones, then the start code (bits 17:16), the opcode (bits 19:18), the PHY address (bits 24:20), the register or device address (bits 29:25), then two turnaround bits, then bits 15:0 MSB first. Start code 01 with opcode 01/10 gives a clause 22 write/read. Start code 00 with opcode 00/01/10/11 gives a clause 45 address/write/read-increment/read.
- R4: For a frame whose opcode bit 19 is 0, the master drives MDIO for all 64 bits, and the turnaround is sent as 1 then 0.
- R5: For a frame whose opcode bit 19 is 1, the output enable is low for bits 46 to 63. MDIO is sampled on each rising MDC edge during bits 48 to 63. The 16 sampled bits appear in bits 15:0, MSB first, in the same cycle that busy clears.
- R6: Read data never carries over from an earlier frame. A read from a PHY that does not answer returns 0xFFFF.
- R7: MDC has a period of 2*HALF system clocks while busy and stays low while idle. MDIO and its enable change only after a falling MDC edge, so they are stable at every rising edge.
- R8: A write to the word while busy is set has no effect on the frame or on the stored fields.
- R9: A soft reset pulse stops any frame and clears every field. The word then reads 0x40000000, MDC is low and MDIO is released.
- R10: After the active-low reset, the word reads 0x40000000, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| reg_wr | input | 1 | Command word write strobe |
| reg_wdata | input | 32 | Command word write data |
| reg_rdata | output | 32 | Command word readback |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The checker takes the following for granted about the inputs:
- `reg_wr` and `soft_rst` are synchronous to `clk`.
- `mdio_i` reflects the shared line.
- HALF is at least 2, so a launch never coincides with an MDC edge.

The bench keeps its stimulus within these assumptions:
- It drives every input on the falling system-clock edge.
- It gives its PHY model control of the line only after a falling MDC edge, and only while the master's enable is low.
- The PHY model releases the line whenever the master is idle.
- Writes made during busy and soft reset pulses each last exactly one cycle.

// File: rtl/mdio_pkg.sv
// Shared frame geometry and command word layout for the MDIO master.
package mdio_pkg;
    localparam int FRAME_LEN = 64;   // bits per management frame
    localparam int PRE_LEN   = 32;   // preamble ones
    localparam int TA_IDX    = 46;   // first turnaround bit index
    localparam int DATA_IDX  = 48;   // first data bit index
    localparam int DATA_W    = 16;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    // Command/status word, bit 31 down to bit 0.
    typedef struct packed {
        logic              busy;
        logic              ready;
        logic [4:0]        reg_dev;
        logic [4:0]        phy;
        logic [1:0]        op;
        logic [1:0]        st;
        logic [DATA_W-1:0] data;
    } mgmt_word_t;
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: divides clk by 2*HALF while enabled and gives one-cycle
// strobes in the clk cycle whose edge makes MDC rise or fall.
// Assumes HALF >= 1; MDC rests low when disabled or cleared.
module mdio_clkgen #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = (cnt == CW'(HALF - 1));

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (clr || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise = en && term && !mdc;
    assign fall = en && term && mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: loads a 64-bit frame at launch, shifts it out on MDC
// falling strobes, releases the line for read turnaround and data, and
// gathers read bits on rising strobes. Assumes launch only while idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              launch,
    input  mgmt_word_t        cmd,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [IDX_W-1:0]     idx;
    logic [FRAME_LEN-1:0] sh;
    logic                 rd_op;

    // Frame sequencing, shift-out and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            sh      <= '1;
            rd_op   <= 1'b0;
            rd_data <= '0;
        end else if (clr) begin
            active  <= 1'b0;
            idx     <= '0;
            sh      <= '1;
            rd_op   <= 1'b0;
            rd_data <= '0;
        end else if (launch) begin
            active  <= 1'b1;
            idx     <= '0;
            sh      <= {{PRE_LEN{1'b1}}, cmd.st, cmd.op, cmd.phy, cmd.reg_dev,
                        2'b10, cmd.data};
            rd_op   <= cmd.op[1];
            rd_data <= '0;
        end else if (active) begin
            if (rise && rd_op && idx >= IDX_W'(DATA_IDX))
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (idx == IDX_W'(FRAME_LEN - 1)) begin
                    active <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                    sh  <= {sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    assign done    = active && fall && (idx == IDX_W'(FRAME_LEN - 1));
    assign mdio_o  = sh[FRAME_LEN-1];
    assign mdio_oe = active && !(rd_op && idx >= IDX_W'(TA_IDX));
endmodule

// File: rtl/mdio_cmd_reg.sv
// Command/status word: accepts writes only while idle, raises launch when
// a write sets busy, and on frame end clears busy and, for reads, loads
// the received data. Assumes done arrives only while busy.
module mdio_cmd_reg
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_data,
    output logic              launch,
    output logic [31:0]       rdata
);
    mgmt_word_t q;
    mgmt_word_t view;

    // Word storage, busy handling and read data update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (done) begin
            q.busy <= 1'b0;
            if (q.op[1])
                q.data <= rx_data;
        end else if (wr && !q.busy) begin
            q       <= mgmt_word_t'(wdata);
            q.ready <= 1'b0;
        end
    end

    assign launch = wr && !q.busy && wdata[31] && !clr;

    // Readback with ready reported as not busy.
    always_comb begin
        view       = q;
        view.ready = !q.busy;
        rdata      = view;
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO master top: ties the command word, MDC generator and frame engine
// together. Assumes CLK_HZ >= 4*MDC_HZ so each MDC half period is >= 2 clks.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int MDC_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int HALF_RAW = CLK_HZ / (2 * MDC_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic              launch;
    logic              active;
    logic              done;
    logic              rise;
    logic              fall;
    logic [DATA_W-1:0] rx_data;

    mdio_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .done    (done),
        .rx_data (rx_data),
        .launch  (launch),
        .rdata   (reg_rdata)
    );

    mdio_clkgen #(.HALF(HALF)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .en    (active),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_frame_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .launch  (launch),
        .cmd     (mgmt_word_t'(reg_wdata)),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .active  (active),
        .done    (done),
        .rd_data (rx_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Port-level checker for mdio_master; counts MDC rises per frame itself.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic       mdc_q;
    logic [6:0] rises;

    // Rising MDC edges seen in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
            rises <= '0;
        end else begin
            mdc_q <= mdc;
            if (!reg_rdata[31])
                rises <= '0;
            else if (mdc && !mdc_q)
                rises <= rises + 1'b1;
        end
    end

    a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[31]) && !$past(soft_rst) |-> rises == 7'd64);

    a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31] && reg_rdata[19] && rises >= 7'd47 |-> !mdio_oe);

    a_r7_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mdc);

    a_r7_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_rdata[31] && !soft_rst |=> reg_rdata[29:16] == $past(reg_rdata[29:16]));

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> reg_rdata == 32'h4000_0000 && !mdio_oe && !mdc);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_test.sv
// Directed bench: one task per scenario plus a simple PHY model on the line.
module mdio_master_test;
    localparam time CLK_PERIOD = 20ns;
    localparam int  CLK_HZ     = 50_000_000;
    localparam int  MDC_HZ     = 2_500_000;
    localparam int  HALF       = CLK_HZ / (2 * MDC_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_tests = 0;
    int n_fail  = 0;

    // PHY model and bus monitor state
    logic        phy_present = 1'b0;
    logic [15:0] phy_resp = '0;
    logic        phy_drive = 1'b0;
    logic        phy_val = 1'b1;
    logic        mdc_prev = 1'b0;
    int          fcount = 0;
    int          tot_rises = 0;
    time         last_rise = 0;
    time         prev_rise = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drive ? phy_val : 1'b1);

    mdio_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Bus monitor: records bits at MDC rises, PHY drives after MDC falls.
    always @(posedge clk) begin
        mdc_prev <= mdc;
        if (!reg_rdata[31]) begin
            fcount    <= 0;
            phy_drive <= 1'b0;
        end else if (mdc && !mdc_prev) begin
            cap_bits  <= {cap_bits[62:0], mdio_o};
            cap_oe    <= {cap_oe[62:0], mdio_oe};
            fcount    <= fcount + 1;
            tot_rises <= tot_rises + 1;
            prev_rise <= last_rise;
            last_rise <= $time;
        end else if (!mdc && mdc_prev) begin
            if (phy_present && fcount == 47) begin
                phy_drive <= 1'b1;
                phy_val   <= 1'b0;
            end else if (phy_present && fcount >= 48 && fcount <= 63) begin
                phy_drive <= 1'b1;
                phy_val   <= phy_resp[63-fcount];
            end else begin
                phy_drive <= 1'b0;
            end
        end
    end

    function automatic logic [63:0] exp_frame(input logic [31:0] w);
        return {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 2'b10, w[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (reg_rdata[31] && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset;
        chk(reg_rdata == 32'h4000_0000, "R10 word", reg_rdata, 64'h4000_0000);
        chk(!mdc && !mdio_oe, "R10 mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_store_only;
        int base;
        logic [31:0] w = 32'h3A54_1234;
        base = tot_rises;
        do_write(w);
        repeat (100) @(negedge clk);
        chk(reg_rdata == {2'b01, w[29:0]}, "R1 readback", reg_rdata, {2'b01, w[29:0]});
        chk(tot_rises == base, "R1 no frame", tot_rises - base, 0);
    endtask

    task automatic t_c22_write;
        int cyc, base;
        logic [31:0] w = {1'b1, 1'b0, 5'h1A, 5'h03, 2'b01, 2'b01, 16'hA55A};
        do_write(w);
        base = tot_rises;
        chk(reg_rdata[31], "R2 busy set", reg_rdata, 64'h1);
        wait_idle(cyc);
        chk(cyc == 128 * HALF, "R2 duration", cyc, 128 * HALF);
        chk(tot_rises - base == 64, "R2 mdc count", tot_rises - base, 64);
        chk(cap_bits == exp_frame(w), "R3 c22 write frame", cap_bits, exp_frame(w));
        chk(cap_oe == '1, "R4 driven all bits", cap_oe, '1);
        chk(reg_rdata == {2'b01, w[29:0]}, "R1 data kept after write", reg_rdata, {2'b01, w[29:0]});
        chk(last_rise - prev_rise == 2 * HALF * CLK_PERIOD, "R7 mdc period",
            last_rise - prev_rise, 2 * HALF * CLK_PERIOD);
    endtask

    task automatic t_read(input logic [31:0] w, input bit present,
                          input logic [15:0] resp, input string tag);
        int cyc;
        logic [15:0] exp_d;
        phy_present = present;
        phy_resp    = resp;
        exp_d       = present ? resp : 16'hFFFF;
        do_write(w);
        wait_idle(cyc);
        chk(cap_bits[63:18] == exp_frame(w) >> 18, {tag, " header"}, cap_bits, exp_frame(w));
        chk(cap_oe == {{46{1'b1}}, 18'h0}, {tag, " oe released"}, cap_oe, {{46{1'b1}}, 18'h0});
        chk(reg_rdata == {2'b01, w[29:16], exp_d}, {tag, " data"}, reg_rdata,
            {2'b01, w[29:16], exp_d});
        phy_present = 1'b0;
    endtask

    task automatic t_c45_addr;
        int cyc;
        logic [31:0] w = {1'b1, 1'b0, 5'h1E, 5'h02, 2'b00, 2'b00, 16'h4321};
        do_write(w);
        wait_idle(cyc);
        chk(cap_bits == exp_frame(w), "R3 c45 address frame", cap_bits, exp_frame(w));
        chk(cap_oe == '1, "R4 c45 address driven", cap_oe, '1);
    endtask

    task automatic t_busy_ignore;
        int cyc;
        logic [31:0] w1 = {1'b1, 1'b0, 5'h05, 5'h11, 2'b01, 2'b01, 16'h0F1E};
        logic [31:0] w2 = {1'b1, 1'b0, 5'h1F, 5'h1F, 2'b10, 2'b00, 16'hFFFF};
        do_write(w1);
        repeat (400) @(negedge clk);
        do_write(w2);
        wait_idle(cyc);
        chk(cap_bits == exp_frame(w1), "R8 frame unchanged", cap_bits, exp_frame(w1));
        chk(reg_rdata == {2'b01, w1[29:0]}, "R8 fields unchanged", reg_rdata, {2'b01, w1[29:0]});
    endtask

    task automatic t_soft_reset;
        int base;
        do_write({1'b1, 1'b0, 5'h01, 5'h01, 2'b10, 2'b01, 16'h0000});
        repeat (300) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(reg_rdata == 32'h4000_0000, "R9 word cleared", reg_rdata, 64'h4000_0000);
        chk(!mdc && !mdio_oe, "R9 mdc low, line released", {mdc, mdio_oe}, 0);
        base = tot_rises;
        repeat (200) @(negedge clk);
        chk(tot_rises == base && !reg_rdata[31], "R9 stays idle", tot_rises - base, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_only();
        t_c22_write();
        t_read({1'b1, 1'b0, 5'h02, 5'h1F, 2'b10, 2'b01, 16'h0000}, 1'b1, 16'h1234, "R5 c22 read");
        t_read({1'b1, 1'b0, 5'h02, 5'h00, 2'b10, 2'b01, 16'h0000}, 1'b0, 16'h0000, "R6 absent phy");
        t_c45_addr();
        t_read({1'b1, 1'b0, 5'h1E, 5'h02, 2'b11, 2'b00, 16'h0000}, 1'b1, 16'hBEEF, "R5 c45 read");
        t_read({1'b1, 1'b0, 5'h1E, 5'h02, 2'b10, 2'b00, 16'h0000}, 1'b1, 16'h0F0F, "R5 c45 read-inc");
        t_read({1'b1, 1'b0, 5'h1E, 5'h02, 2'b11, 2'b00, 16'h0000}, 1'b0, 16'h0000, "R6 c45 absent");
        t_busy_ignore();
        t_soft_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule